// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Cache

This block lets a bus master read serial flash as if it were plain memory. It answers 32-bit read requests on a linear address window. It holds one 1 KB window of flash data in a local buffer, together with the bus address that the window starts at. A read that falls inside the window is answered in the same cycle it is presented.

A read outside the window holds the request stalled while the block refills the buffer. It lowers the chip select of the flash device that owns the address and sends a read frame. The frame carries a command byte, a 24-bit address, an optional mode byte and a configurable run of dummy bytes. The block then clocks in 1024 data bytes, raises every chip select, and completes the stalled read from the new window.

The serial side is a byte-level transfer port: the block presents one byte with a request, and a serializer returns the byte it received when it acknowledges. A small configuration register sets the frame contents and the dual-device addressing. Requests other than aligned words are answered at once with an error.

Top module: `flash_read_cache`

## Requirements
- R1: A word read is a hit when the cache holds a valid window and base <= addr <= base + 1020. A hit gets rd_ready in the same cycle as rd_valid, with rd_data equal to buffer word (addr - base)/4 and no serial transfer.
- R2: On a miss, the device index is the flash address shifted right by 24, so each device covers 16 MB. Only cs_n bit equal to that index is driven low (active low) while the frame runs.
- R3: With the dual-device flag set, the flash address is the bus address divided by two. With the flag clear, it equals the bus address.
- R4: Each refill frame begins with the command byte, then the three bytes of the 24-bit flash address, most significant byte first.
- R5: When mode-enable is set, one mode byte follows the address. Then come as many 0x00 dummy bytes as the 3-bit dummy count. Bytes received during these header bytes are discarded.
- R6: After the header, the block transmits 1024 bytes of 0x00 and stores the 1024 received bytes. Word i of the window holds received bytes 4i..4i+3 little-endian, with the first byte in bits 7:0.
- R7: After the last data byte, every cs_n bit returns high before the stalled read completes. The new window base is the address that missed.
- R8: After reset, no window is valid, so the first read misses. The configuration equals the word 0x03A002EB decoded as: command in bits 7:0 (0xEB), dummy count in bits 10:8 (2), mode byte in bits 23:16 (0xA0), mode-enable in bit 25 (1), dual-device flag in bit 30 (0).
- R9: A request with rd_size other than 2'b10 (codes: 0 byte, 1 half, 2 word, 3 reserved), or with rd_addr[1:0] nonzero, gets rd_ready with rd_err high in the same cycle and starts no serial transfer.
- R10: Once spi_req rises, it stays high with spi_tx unchanged until spi_ack is seen at a clock edge.
- R11: A configuration write (cfg_we high for one cycle) applies to the next refill. It does not invalidate the window already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | ADDR_W (25) | Byte address inside the linear window |
| rd_size | input | 2 | Access size code; only 2'b10 (word) is accepted |
| rd_ready | output | 1 | Request completes in this cycle |
| rd_data | output | 32 | Read data, valid with rd_ready |
| rd_err | output | 1 | Error response, valid with rd_ready |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_opcode | input | 8 | Read command byte |
| cfg_mode_en | input | 1 | Send a mode byte after the address |
| cfg_mode_byte | input | 8 | Mode byte value |
| cfg_dummy_cnt | input | 3 | Number of dummy bytes |
| cfg_dual | input | 1 | Dual-device addressing (flash address = bus address / 2) |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Transfer done at this edge |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| cs_n | output | NUM_CS (2) | Active-low device selects |

## Verification
The embedded assertions watch the properties that hold cycle by cycle. These are: at most one select low while a transfer is requested, a request held steady until acknowledged, no completion while a device is still selected, no serial activity on an error answer, and no buffer write while the window counts as valid. What only the bench scenarios can show is whether the content is right. That covers the exact header bytes for each configuration, the dual-device and second-device address mapping, the byte packing of all 256 words, the hit window edges on both sides of the base, and the fact that a configuration write leaves the held window usable.

// File: rtl/fcache_pkg.sv
// Shared types for the serial flash read cache.
package fcache_pkg;
    // Sequencer phase of a refill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } fc_state_t;

    // Header shaping fields.
    typedef struct packed {
        logic [7:0] op;
        logic       mode_en;
        logic [7:0] mode;
        logic [2:0] dummies;
    } fc_hdr_cfg_t;

    localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/fcache_frame.sv
// Header byte generator.
// Picks the header byte for a given position and reports the header length.
// Assumes the caller steps idx from 0 to len-1.
module fcache_frame
    import fcache_pkg::*;
(
    input  fc_hdr_cfg_t hcfg,
    input  logic [23:0] flash_addr,
    input  logic [3:0]  idx,
    output logic [7:0]  hdr_byte,
    output logic [3:0]  hdr_len
);
    // Length: command + 3 address bytes + optional mode + dummies.
    always_comb begin
        hdr_len = 4'd4 + 4'(hcfg.mode_en) + 4'(hcfg.dummies);
    end

    // Byte for the current header position.
    always_comb begin
        case (idx)
            4'd0:    hdr_byte = hcfg.op;
            4'd1:    hdr_byte = flash_addr[23:16];
            4'd2:    hdr_byte = flash_addr[15:8];
            4'd3:    hdr_byte = flash_addr[7:0];
            4'd4:    hdr_byte = hcfg.mode_en ? hcfg.mode : 8'h00;
            default: hdr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/fcache_store.sv
// Window buffer with base tag.
// Holds LINE_BYTES of data and the bus address they start at, and answers hit lookups.
// Assumes byte writes arrive only while the window is invalid.
module fcache_store #(
    parameter int ADDR_W     = 25,
    parameter int LINE_BYTES = 1024,
    localparam int WORDS     = LINE_BYTES / 4,
    localparam int BCNT_W    = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [31:0]       rd_word,
    input  logic              wr_en,
    input  logic [BCNT_W-1:0] wr_ofs,
    input  logic [7:0]        wr_byte,
    input  logic              commit,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              invalidate
);
    logic [31:0]       mem [WORDS];
    logic              valid_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ofs;

    // Byte-lane write of refill data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ofs[BCNT_W-1:2]][8*wr_ofs[1:0] +: 8] <= wr_byte;
        end
    end

    // Base tag and validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            base_q  <= '1;
        end else if (commit) begin
            valid_q <= 1'b1;
            base_q  <= commit_addr;
        end else if (invalidate) begin
            valid_q <= 1'b0;
        end
    end

    // Window compare and word select.
    always_comb begin
        ofs     = look_addr - base_q;
        hit     = valid_q && (look_addr >= base_q) && (ofs <= ADDR_W'(LINE_BYTES - 4));
        rd_word = mem[ofs[BCNT_W-1:2]];
    end

    AST_FILL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid_q); // R7
endmodule

// File: rtl/fcache_seq.sv
// Refill sequencer.
// Selects the device, walks the header, fills the buffer, then deselects.
// Assumes ADDR_W >= 24 and that miss_start is only raised while idle.
module fcache_seq
    import fcache_pkg::*;
#(
    parameter int ADDR_W      = 25,
    parameter int LINE_BYTES  = 1024,
    parameter int NUM_CS      = 2,
    parameter int SLAVE_SHIFT = 24,
    localparam int BCNT_W     = $clog2(LINE_BYTES),
    localparam int SLV_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  fc_hdr_cfg_t       hcfg,
    input  logic              dual,
    output fc_state_t         state,
    output fc_hdr_cfg_t       hcfg_l,
    output logic [23:0]       fa_l,
    output logic [3:0]        hdr_idx,
    input  logic [7:0]        hdr_byte,
    input  logic [3:0]        hdr_len,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    output logic [NUM_CS-1:0] cs_n,
    output logic              wr_en,
    output logic [BCNT_W-1:0] wr_ofs,
    output logic [7:0]        wr_byte,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr
);
    fc_state_t         st_q;
    logic [BCNT_W-1:0] cnt_q;
    logic [SLV_W-1:0]  slv_q;
    logic [ADDR_W-1:0] req_q;
    logic [ADDR_W-1:0] fa_full;
    logic              xfer;
    logic              hdr_last;
    logic              data_last;
    logic              framing;

    // Flash address from bus address and device mode.
    always_comb begin
        fa_full   = dual ? (req_addr >> 1) : req_addr;
        xfer      = spi_req && spi_ack;
        hdr_last  = (cnt_q == (BCNT_W'(hdr_len) - BCNT_W'(1)));
        data_last = (cnt_q == BCNT_W'(LINE_BYTES - 1));
        framing   = (st_q == ST_HDR) || (st_q == ST_DATA);
    end

    // Phase and byte counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            slv_q  <= '0;
            req_q  <= '0;
            fa_l   <= '0;
            hcfg_l <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (miss_start) begin
                    fa_l   <= fa_full[23:0];
                    slv_q  <= SLV_W'(fa_full >> SLAVE_SHIFT);
                    req_q  <= req_addr;
                    hcfg_l <= hcfg;
                    cnt_q  <= '0;
                    st_q   <= ST_HDR;
                end
                ST_HDR: if (xfer) begin
                    if (hdr_last) begin
                        cnt_q <= '0;
                        st_q  <= ST_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: if (xfer) begin
                    if (data_last) begin
                        cnt_q <= '0;
                        st_q  <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Transfer port and buffer write strobes.
    always_comb begin
        state       = st_q;
        hdr_idx     = cnt_q[3:0];
        spi_req     = framing;
        spi_tx      = (st_q == ST_HDR) ? hdr_byte : 8'h00;
        wr_en       = (st_q == ST_DATA) && xfer;
        wr_ofs      = cnt_q;
        wr_byte     = spi_rx;
        commit      = wr_en && data_last;
        commit_addr = req_q;
    end

    // One select line per device, low only for the chosen one.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(framing && (slv_q == SLV_W'(g)));
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> ($countones(~cs_n) == 1)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx))); // R10
endmodule

// File: rtl/flash_read_cache.sv
// Memory-mapped serial flash read cache, top level.
// Serves aligned word reads from a one-window buffer and refills it over a byte transfer port.
// Assumes rd_valid and its address stay stable until rd_ready.
module flash_read_cache
    import fcache_pkg::*;
#(
    parameter int          ADDR_W      = 25,
    parameter int          LINE_BYTES  = 1024,
    parameter int          NUM_CS      = 2,
    parameter int          SLAVE_SHIFT = 24,
    parameter logic [31:0] CFG_INIT    = 32'h03A002EB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              rd_err,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_opcode,
    input  logic              cfg_mode_en,
    input  logic [7:0]        cfg_mode_byte,
    input  logic [2:0]        cfg_dummy_cnt,
    input  logic              cfg_dual,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int BCNT_W = $clog2(LINE_BYTES);
    localparam fc_hdr_cfg_t INIT_HCFG = '{op: CFG_INIT[7:0], mode_en: CFG_INIT[25],
                                          mode: CFG_INIT[23:16], dummies: CFG_INIT[10:8]};

    fc_hdr_cfg_t       hcfg_q, hcfg_l;
    logic              dual_q;
    fc_state_t         state;
    logic [23:0]       fa_l;
    logic [3:0]        hdr_idx, hdr_len;
    logic [7:0]        hdr_byte;
    logic              hit, bad, serve_ok, miss_start;
    logic [31:0]       rd_word;
    logic              wr_en, commit;
    logic [BCNT_W-1:0] wr_ofs;
    logic [7:0]        wr_byte;
    logic [ADDR_W-1:0] commit_addr;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcfg_q <= INIT_HCFG;
            dual_q <= CFG_INIT[30];
        end else if (cfg_we) begin
            hcfg_q <= '{op: cfg_opcode, mode_en: cfg_mode_en,
                        mode: cfg_mode_byte, dummies: cfg_dummy_cnt};
            dual_q <= cfg_dual;
        end
    end

    // Bus response and miss detection.
    always_comb begin
        bad        = (rd_size != SZ_WORD) || (rd_addr[1:0] != 2'b00);
        serve_ok   = (state == ST_IDLE) || (state == ST_DONE);
        rd_ready   = rd_valid && serve_ok && (bad || hit);
        rd_err     = rd_ready && bad;
        rd_data    = bad ? 32'h0 : rd_word;
        miss_start = rd_valid && (state == ST_IDLE) && !bad && !hit;
    end

    fcache_store #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .look_addr(rd_addr), .hit(hit), .rd_word(rd_word),
        .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_byte(wr_byte), .commit(commit),
        .commit_addr(commit_addr), .invalidate(miss_start)
    );

    fcache_frame u_frame (
        .hcfg(hcfg_l), .flash_addr(fa_l), .idx(hdr_idx), .hdr_byte(hdr_byte), .hdr_len(hdr_len)
    );

    fcache_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_CS(NUM_CS),
                 .SLAVE_SHIFT(SLAVE_SHIFT)) u_seq (
        .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .req_addr(rd_addr),
        .hcfg(hcfg_q), .dual(dual_q), .state(state), .hcfg_l(hcfg_l), .fa_l(fa_l),
        .hdr_idx(hdr_idx), .hdr_byte(hdr_byte), .hdr_len(hdr_len),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .cs_n(cs_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_byte(wr_byte),
        .commit(commit), .commit_addr(commit_addr)
    );

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (&cs_n)); // R7
    AST_ERR_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && rd_err) |-> !spi_req); // R9
endmodule

// File: tb/flash_read_cache_bench.sv
`timescale 1ns/1ps
module flash_read_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [24:0] rd_addr = '0;
    logic [1:0]  rd_size = 2'b10;
    logic        rd_ready, rd_err;
    logic [31:0] rd_data;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_opcode = '0, cfg_mode_byte = '0;
    logic        cfg_mode_en = 1'b0, cfg_dual = 1'b0;
    logic [2:0]  cfg_dummy_cnt = '0;
    logic        spi_req, spi_ack;
    logic [7:0]  spi_tx;
    logic [7:0]  spi_rx = 8'h00;
    logic [1:0]  cs_n;

    always #2.5 clk = ~clk;

    flash_read_cache u_flash_read_cache (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err), .cfg_we(cfg_we),
        .cfg_opcode(cfg_opcode), .cfg_mode_en(cfg_mode_en), .cfg_mode_byte(cfg_mode_byte),
        .cfg_dummy_cnt(cfg_dummy_cnt), .cfg_dual(cfg_dual), .spi_req(spi_req),
        .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx), .cs_n(cs_n)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model state.
    bit         m_valid = 0;
    int         m_base = 0, m_fa = 0, m_slv = 0;
    logic [7:0] m_op = 8'hEB, m_mode = 8'hA0;
    bit         m_men = 1, m_dual = 0;
    int         m_dum = 2;
    bit         in_miss = 0;
    int         exp_slv = 0, exp_hlen = 4;
    bit         slow = 1, gate = 1;
    logic [7:0] ftx[$];
    int         fk = 0;

    function automatic logic [7:0] fb(int s, int f);
        return 8'((f & 255) + ((f >> 8) & 255) * 7 + ((f >> 16) & 255) * 13 + s * 90 + 1);
    endfunction

    function automatic logic [31:0] ew(int s, int fa, int i);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[8*j +: 8] = fb(s, fa + 4*i + j);
        return w;
    endfunction

    assign spi_ack = spi_req & gate;

    // Flash model and per-cycle select check.
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_req)
                chk(in_miss && (cs_n == ~(2'(1) << exp_slv)), "R2", "select during transfer",
                    cs_n, ~(2'(1) << exp_slv));
            else if (!in_miss)
                chk(&cs_n, "R7", "idle selects", cs_n, 2'b11);
        end
        gate <= slow ? ~gate : 1'b1;
        if (fk < exp_hlen || ftx.size() < 4) spi_rx = 8'hC3;
        else spi_rx = fb(cs_n[1] ? 0 : 1, {ftx[1], ftx[2], ftx[3]} + fk - exp_hlen);
        #2;
        if (spi_req && spi_ack) begin
            ftx.push_back(spi_tx);
            fk = fk + 1;
        end else if (&cs_n) begin
            fk = 0;
        end
    end

    task automatic set_cfg(input logic [7:0] op, input bit men, input logic [7:0] md,
                           input int dum, input bit dual);
        @(negedge clk);
        cfg_we = 1; cfg_opcode = op; cfg_mode_en = men; cfg_mode_byte = md;
        cfg_dummy_cnt = 3'(dum); cfg_dual = dual;
        @(posedge clk); #1;
        cfg_we = 0;
        m_op = op; m_men = men; m_mode = md; m_dum = dum; m_dual = dual;
    endtask

    task automatic do_read(input int addr, input logic [1:0] sz, input string req);
        bit bad = (sz != 2'b10) || ((addr & 3) != 0);
        bit hit = !bad && m_valid && addr >= m_base && addr <= m_base + 1020;
        int fa = 0, slv = 0, hl = 0, n = 0, bad_hdr = 0, bad_dat = 0;
        logic [7:0] eh[12];
        if (!bad && !hit) begin
            fa = m_dual ? (addr >> 1) : addr;
            slv = (fa >> 24) & 1;
            fa = fa & 32'hFFFFFF;
            hl = 4 + int'(m_men) + m_dum;
            exp_slv = slv; exp_hlen = hl; in_miss = 1;
        end
        ftx.delete();
        @(negedge clk);
        rd_valid = 1; rd_addr = 25'(addr); rd_size = sz;
        #1;
        while (!rd_ready && n < 20000) begin
            @(negedge clk); #1; n++;
        end
        if (bad) begin
            chk(rd_err == 1'b1, "R9", "error flag", rd_err, 1);
            chk(n == 0 && ftx.size() == 0, "R9", "error latency/transfers", n, 0);
        end else if (hit) begin
            chk(n == 0 && ftx.size() == 0, req, "hit latency/transfers", n, 0);
            chk(rd_data == ew(m_slv, m_fa, (addr - m_base) / 4) && !rd_err, req, "hit data",
                rd_data, ew(m_slv, m_fa, (addr - m_base) / 4));
        end else begin
            chk(ftx.size() == hl + 1024, "R6", "frame length", ftx.size(), hl + 1024);
            eh[0] = m_op; eh[1] = 8'(fa >> 16); eh[2] = 8'(fa >> 8); eh[3] = 8'(fa);
            for (int k = 4; k < 12; k++) eh[k] = (k == 4 && m_men) ? m_mode : 8'h00;
            for (int k = 0; k < 4; k++) if (ftx.size() > k && ftx[k] != eh[k]) bad_hdr++;
            chk(bad_hdr == 0, "R4", "command/address bytes", bad_hdr, 0);
            bad_hdr = 0;
            for (int k = 4; k < hl; k++) if (ftx.size() > k && ftx[k] != eh[k]) bad_hdr++;
            chk(bad_hdr == 0, "R5", "mode/dummy bytes", bad_hdr, 0);
            for (int k = hl; k < ftx.size(); k++) if (ftx[k] != 8'h00) bad_dat++;
            chk(bad_dat == 0, "R6", "data phase tx zero", bad_dat, 0);
            m_valid = 1; m_base = addr; m_fa = fa; m_slv = slv;
            // R5/R6: header rx discarded, first data byte in bits 7:0
            chk(rd_data == ew(slv, fa, 0) && !rd_err, req, "miss completion data",
                rd_data, ew(slv, fa, 0));
        end
        @(posedge clk); #1;
        rd_valid = 0;
        in_miss = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(cs_n == 2'b11 && !spi_req && !rd_ready, "R8", "reset outputs",
            {cs_n, spi_req, rd_ready}, 4'b1100);
        // R8: first access misses and uses the reset configuration
        do_read(32'h0000100, 2'b10, "R8");
        do_read(32'h0000100 + 1020, 2'b10, "R1");
        do_read(32'h0000100 + 512, 2'b10, "R1");
        for (int i = 0; i < 256; i++) do_read(32'h0000100 + 4*i, 2'b10, "R6");
        do_read(32'h0000104, 2'b00, "R9");
        do_read(32'h0000102, 2'b10, "R9");
        do_read(32'h0000104, 2'b11, "R9");
        slow = 0;
        do_read(32'h0000500, 2'b10, "R1");   // base + 1024 misses
        do_read(32'h00004FC, 2'b10, "R1");   // below base misses
        do_read(32'h0000500, 2'b10, "R1");   // base + 4 hits
        do_read(32'h1000040, 2'b10, "R2");   // second device
        do_read(32'h1000040 + 8, 2'b10, "R2");
        set_cfg(8'h0B, 0, 8'h00, 0, 1);
        do_read(32'h1000040 + 1020, 2'b10, "R11");
        do_read(32'h0000800, 2'b10, "R3");
        do_read(32'h0000804, 2'b10, "R3");
        do_read(32'h1FFFFFC, 2'b10, "R3");
        slow = 1;
        set_cfg(8'h03, 0, 8'h00, 5, 0);
        do_read(32'h0123450, 2'b10, "R5");
        set_cfg(8'h6B, 1, 8'h5C, 7, 0);
        do_read(32'h0012340, 2'b10, "R5");
        do_read(32'h0012340 + 4, 2'b10, "R7");   // new base is the missed address
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule